// File: doc/BRIEF.md
# Two's Complement Add/Subtract Unit with Condition Flags

This block adds or subtracts two 8-bit two's complement operands on a single ripple-carry adder and reports the usual condition flags with the result. When the mode select is high, the second operand is bit-inverted before it enters the adder and the adder's lowest carry input is forced to 1, so `a - b` is computed as `a + ~b + 1` with no second adder.

The flags are sign (top result bit), carry, overflow and zero. In subtract mode the carry flag means a borrow, so it is the complement of the adder's carry-out. Overflow comes from the carry into the top bit and the carry out of it. The adder's raw carry-out is also brought out unchanged for debug. A parameter places a register stage on all outputs, with asynchronous active-low reset. With the default setting the block is purely combinational.

Top module: `addsub_flags`

## Requirements
- R1: With `sub_i`=0, `res_o` equals (`a_i` + `b_i`) modulo 256. The adder receives `b_i` unchanged and a carry-in of 0.
- R2: With `sub_i`=1, `res_o` equals (`a_i` - `b_i`) modulo 256. It is formed as `a_i` + bitwise-NOT `b_i` with the adder carry-in set to 1.
- R3: `of_o` is 1 exactly when the true signed result falls outside -128..+127. It equals the carry out of bit 7 XOR the carry into bit 7.
- R4: `sf_o` equals bit 7 of `res_o`.
- R5: When adding, `cf_o` equals the adder carry-out, which is 1 when the unsigned sum exceeds 255. When subtracting, `cf_o` equals the carry-out XOR 1, which is 1 when `a_i` < `b_i` unsigned (a borrow).
- R6: `zf_o` is 1 exactly when all 8 bits of `res_o` are 0.
- R7: `cout_o` is the adder's raw carry-out in both modes. When subtracting, it is 1 when `a_i` >= `b_i` unsigned.
- R8: -115 minus -100 (0x8D minus 0x9C, `sub_i`=1) gives `res_o`=0xF1, `sf_o`=1, `cf_o`=1, `of_o`=0, `zf_o`=0, `cout_o`=0.
- R9: With `REG_OUT`=1, every output shows the value for the inputs present at the previous rising edge of `clk_i`. While `rst_ni` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage and for the checks |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| res_o | output | 8 | Result |
| sf_o | output | 1 | Sign flag |
| cf_o | output | 1 | Carry flag (borrow when subtracting) |
| of_o | output | 1 | Signed overflow flag |
| zf_o | output | 1 | Zero flag |
| cout_o | output | 1 | Raw adder carry-out |

## Verification
The assertions sample the combinational adder at each rising edge. They therefore assume that `a_i`, `b_i` and `sub_i` are stable and free of X around that edge, and that they change only between edges. The bench meets this by driving every input on the falling edge, including the exhaustive sweep over all operand pairs in both modes, the seeded random vectors and the directed corner cases. It also holds the inputs at known values while reset is asserted.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sub_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o,
  output logic         sf_o,
  output logic         cf_o,
  output logic         of_o,
  output logic         zf_o,
  output logic         cout_o
);

  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [W:0]   cy;
  logic         sf_w, cf_w, of_w, zf_w;

  assign b_eff = b_i ^ {W{sub_i}};
  assign cy[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a_i[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1] = (a_i[i] & b_eff[i]) | (cy[i] & (a_i[i] ^ b_eff[i]));
  end

  assign sf_w = sum[W-1];
  assign cf_w = cy[W] ^ sub_i;
  assign of_w = cy[W] ^ cy[W-1];
  assign zf_w = ~|sum;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o  <= '0;
        sf_o   <= 1'b0;
        cf_o   <= 1'b0;
        of_o   <= 1'b0;
        zf_o   <= 1'b0;
        cout_o <= 1'b0;
      end else begin
        res_o  <= sum;
        sf_o   <= sf_w;
        cf_o   <= cf_w;
        of_o   <= of_w;
        zf_o   <= zf_w;
        cout_o <= cy[W];
      end
    end

    p_reg_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (res_o == $past(sum) && cout_o == $past(cy[W])));
  end else begin : g_comb
    assign res_o  = sum;
    assign sf_o   = sf_w;
    assign cf_o   = cf_w;
    assign of_o   = of_w;
    assign zf_o   = zf_w;
    assign cout_o = cy[W];
  end

  p_add_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |-> sum == W'(a_i + b_i));

  p_sub_diff_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> sum == W'(a_i - b_i));

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    of_w == ((a_i[W-1] == (b_i[W-1] ^ sub_i)) && (sum[W-1] != a_i[W-1])));

  p_borrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> cf_w == (a_i < b_i));

  p_add_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_i |-> cf_w == (({1'b0, a_i} + {1'b0, b_i}) > {1'b0, {W{1'b1}}}));

  p_zero_equal_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> zf_w == (a_i == b_i));

  p_raw_carry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sub_i |-> cy[W] == (a_i >= b_i));

endmodule

// File: tb/addsub_flags_tb_top.sv
`timescale 1ns/1ps
module addsub_flags_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub;
  logic [7:0] a, b;
  logic [7:0] r_res, c_res;
  logic       r_sf, r_cf, r_of, r_zf, r_co;
  logic       c_sf, c_cf, c_of, c_zf, c_co;
  int         checks = 0;
  int         failures = 0;

  always #2.5 clk = ~clk;

  addsub_flags #(.W(8), .REG_OUT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sub_i(sub), .a_i(a), .b_i(b),
    .res_o(r_res), .sf_o(r_sf), .cf_o(r_cf), .of_o(r_of), .zf_o(r_zf), .cout_o(r_co));

  addsub_flags #(.W(8), .REG_OUT(1'b0)) dut_comb_i (
    .clk_i(clk), .rst_ni(rst_n), .sub_i(sub), .a_i(a), .b_i(b),
    .res_o(c_res), .sf_o(c_sf), .cf_o(c_cf), .of_o(c_of), .zf_o(c_zf), .cout_o(c_co));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [7:0] x, input logic [7:0] y, input logic s,
                       output logic [7:0] res, output logic sf, output logic cf,
                       output logic of, output logic zf, output logic co);
    int sx, sy, tr, ux, uy;
    sx = $signed(x); sy = $signed(y); ux = x; uy = y;
    tr = s ? sx - sy : sx + sy;
    res = s ? 8'(ux - uy) : 8'(ux + uy);
    sf = res[7];
    of = (tr < -128) || (tr > 127);
    zf = (res == 8'h00);
    cf = s ? (ux < uy) : (ux + uy > 255);
    co = s ? (ux >= uy) : (ux + uy > 255);
  endtask

  task automatic compare(input string who, input logic [7:0] res, input logic sf,
                         input logic cf, input logic of, input logic zf, input logic co,
                         input logic [7:0] x, input logic [7:0] y, input logic s);
    logic [7:0] er;
    logic esf, ecf, eof, ezf, eco;
    model(x, y, s, er, esf, ecf, eof, ezf, eco);
    check({who, s ? " R2 result" : " R1 result"}, res, er);
    check({who, " R4 sign"}, {7'd0, sf}, {7'd0, esf});
    check({who, " R5 carry"}, {7'd0, cf}, {7'd0, ecf});
    check({who, " R3 overflow"}, {7'd0, of}, {7'd0, eof});
    check({who, " R6 zero"}, {7'd0, zf}, {7'd0, ezf});
    check({who, " R7 raw carry"}, {7'd0, co}, {7'd0, eco});
  endtask

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic s);
    @(negedge clk);
    a = x; b = y; sub = s;
    #1;
    compare("comb", c_res, c_sf, c_cf, c_of, c_zf, c_co, x, y, s);
    @(posedge clk);
    #1;
    compare("R9 reg", r_res, r_sf, r_cf, r_of, r_zf, r_co, x, y, s);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] ra, rb;
    logic rs;
    int seed;
    a = 8'h8D; b = 8'h9C; sub = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset res", r_res, 8'h00);
    check("R9 reset flags", {3'd0, r_sf, r_cf, r_of, r_zf, r_co}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    apply(8'h8D, 8'h9C, 1'b1);
    check("R8 result", r_res, 8'hF1);
    check("R8 flags sf cf of zf cout", {3'd0, r_sf, r_cf, r_of, r_zf, r_co}, 8'b00011000);

    apply(8'h7F, 8'h01, 1'b0);
    apply(8'h80, 8'h01, 1'b1);
    apply(8'h80, 8'h80, 1'b0);
    apply(8'h00, 8'h00, 1'b1);
    apply(8'h00, 8'h01, 1'b1);
    apply(8'hFF, 8'h01, 1'b0);
    apply(8'h5A, 8'h5A, 1'b1);

    seed = 32'h1F2E3D4C;
    void'($urandom(seed));
    for (int k = 0; k < 400; k++) begin
      ra = 8'($urandom()); rb = 8'($urandom()); rs = 1'($urandom());
      apply(ra, rb, rs);
    end

    for (int s = 0; s < 2; s++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y++)
          apply(8'(x), 8'(y), 1'(s));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule